// File: doc/BRIEF.md
# Graph Neighbour Aggregation Unit with Replica Address Lookup

This unit sits next to a feature memory and performs the neighbour-aggregation step of a graph network layer. A producer pushes edges, each carrying a source vertex ID, a destination index and an unsigned weight, into a small in-order edge queue. Only the edge at the head of the queue is worked on, and it leaves the queue only when the controller has finished with it. For that edge the controller resolves the source vertex to a feature-memory address. IDs below a parameterised local limit map directly to their own address. Any other ID is looked up in a content-addressable table whose entries pair a remote vertex ID with the address where its replica feature is stored.

With the address resolved, the controller issues one read to the feature memory. On the next cycle a lane-parallel multiply-accumulate array adds weight × feature into the destination's entry of an on-chip vertex feature buffer. An edge whose remote source is not found in the table is discarded and sets a sticky error flag. A drain request streams out every buffer entry in ascending index order and clears each entry as it is read.

Top module: `gagg_top`

## Requirements
- R1: Edges are kept in a first-in first-out queue of FIFO_DEPTH entries and processed oldest first. `edge_ready` is low exactly when the queue is full, and an edge is accepted on a clock edge where `edge_valid` and `edge_ready` are both high.
- R2: A source ID below LOCAL_LIMIT is local, and its feature address is the low ADDR_W bits of the ID (with the default values, IDs 0..7 read addresses 0..7 and ID 8 is the first remote ID).
- R3: A remote source is looked up in the CAM. On a hit, the stored address is used. If several valid entries hold the same ID, the entry with the lowest index wins. A write through the CAM port replaces the entry at `cam_wr_idx` and takes effect from the next cycle.
- R4: A remote source that misses the CAM is removed from the queue without any feature read and without changing any buffer entry. It sets `miss_err` on the following cycle, and `miss_err` then stays high until reset.
- R5: For an accepted edge, buffer entry `dst` lane i becomes its old value plus `wgt × feature lane i`. The arithmetic is unsigned and wraps modulo 2^ACC_W. Lane i occupies bits [i*W +: W] of both the feature word and the output word.
- R6: The feature read has a latency of one cycle. `fm_rd_en` is high for one cycle with the resolved `fm_rd_addr`, `fm_rd_data` is taken on the next cycle, and that is the cycle in which the accumulation happens. Each edge costs two cycles.
- R7: When the unit is idle, `drain_req` starts a drain. For NUM_DST consecutive cycles `out_valid` is high and `out_idx` counts 0, 1, … NUM_DST-1, with `out_data` carrying that entry. Each entry reads zero afterwards.
- R8: No feature reads or accumulations occur during a drain. Edges pushed during a drain wait in the queue and are applied after it.
- R9: After reset the queue is empty, all buffer entries are zero, `miss_err`, `out_valid` and `busy` are low, and `edge_ready` is high. `busy` is high while a drain runs, while an edge is in flight, or while the queue holds an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_valid | input | 1 | Edge push request |
| edge_ready | output | 1 | Queue can accept an edge |
| edge_src | input | VID_W | Source vertex ID |
| edge_dst | input | DST_W | Destination buffer index |
| edge_wgt | input | WGT_W | Edge weight, unsigned |
| cam_wr_en | input | 1 | Write one CAM entry |
| cam_wr_idx | input | CAM_IDX_W | CAM entry to write |
| cam_wr_vid | input | VID_W | Remote vertex ID key |
| cam_wr_addr | input | ADDR_W | Replica feature address |
| fm_rd_en | output | 1 | Feature memory read strobe |
| fm_rd_addr | output | ADDR_W | Feature memory read address |
| fm_rd_data | input | LANES*FEAT_W | Feature word, one cycle after the strobe |
| drain_req | input | 1 | Start a drain when idle |
| out_valid | output | 1 | Drain output valid |
| out_idx | output | DST_W | Index of the entry being drained |
| out_data | output | LANES*ACC_W | Accumulated entry |
| busy | output | 1 | Work pending or in progress |
| miss_err | output | 1 | Sticky CAM-miss flag |

## Verification
The hardest case to reach from the ports is the full queue. Edges normally leave the queue two cycles after they arrive, so the queue only fills when the controller is held in a drain. The stimulus starts a drain and pushes edges on every cycle while it runs, which shows `edge_ready` falling and also that the queued edges are applied only after the drain. CAM priority is reached by loading a duplicate key at a higher index and then overwriting the lower entry, so the same source ID resolves to two different addresses over the course of the run.

// File: rtl/gagg_pkg.sv
package gagg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACC   = 2'd1,
    ST_DRAIN = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/gagg_edge_fifo.sv
module gagg_edge_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [PW:0]   cnt;

  assign full_o  = (cnt == (PW+1)'(DEPTH));
  assign empty_o = (cnt == '0);
  assign dout_o  = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_i) begin
        mem[wptr] <= din_i;
        wptr      <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      end
      if (pop_i) rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      if (push_i && !pop_i)      cnt <= cnt + 1'b1;
      else if (!push_i && pop_i) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/gagg_cam.sv
module gagg_cam #(
  parameter int ENTRIES = 4,
  parameter int KEY_W   = 8,
  parameter int VAL_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  logic [VAL_W-1:0] wr_val_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             hit_o,
  output logic [VAL_W-1:0] val_o
);
  logic [ENTRIES-1:0] vld_q;
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [VAL_W-1:0]   val_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign match[g] = vld_q[g] && (key_q[g] == key_i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        key_q[g] <= '0;
        val_q[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        vld_q[g] <= 1'b1;
        key_q[g] <= wr_key_i;
        val_q[g] <= wr_val_i;
      end
    end
  end

  // Lowest matching index wins: scan downward so it is assigned last.
  always_comb begin
    hit_o = 1'b0;
    val_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        val_o = val_q[i];
      end
    end
  end
endmodule

// File: rtl/gagg_mac.sv
module gagg_mac #(
  parameter int LANES  = 4,
  parameter int FEAT_W = 8,
  parameter int WGT_W  = 8,
  parameter int ACC_W  = 24
) (
  input  logic [LANES*ACC_W-1:0]  acc_i,
  input  logic [LANES*FEAT_W-1:0] feat_i,
  input  logic [WGT_W-1:0]        wgt_i,
  output logic [LANES*ACC_W-1:0]  acc_o
);
  localparam int PROD_W = FEAT_W + WGT_W;

  function automatic logic [ACC_W-1:0] mac_lane(
    input logic [ACC_W-1:0]  a,
    input logic [FEAT_W-1:0] f,
    input logic [WGT_W-1:0]  w
  );
    logic [PROD_W-1:0] p;
    p = PROD_W'(f) * PROD_W'(w);
    return a + ACC_W'(p);
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign acc_o[g*ACC_W +: ACC_W] =
      mac_lane(acc_i[g*ACC_W +: ACC_W], feat_i[g*FEAT_W +: FEAT_W], wgt_i);
  end
endmodule

// File: rtl/gagg_top.sv
module gagg_top #(
  parameter int VID_W       = 8,
  parameter int ADDR_W      = 4,
  parameter int LOCAL_LIMIT = 8,
  parameter int NUM_DST     = 8,
  parameter int LANES       = 4,
  parameter int FEAT_W      = 8,
  parameter int WGT_W       = 8,
  parameter int ACC_W       = 24,
  parameter int FIFO_DEPTH  = 4,
  parameter int CAM_ENTRIES = 4,
  localparam int DST_W      = $clog2(NUM_DST),
  localparam int CAM_IDX_W  = $clog2(CAM_ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    edge_valid,
  output logic                    edge_ready,
  input  logic [VID_W-1:0]        edge_src,
  input  logic [DST_W-1:0]        edge_dst,
  input  logic [WGT_W-1:0]        edge_wgt,
  input  logic                    cam_wr_en,
  input  logic [CAM_IDX_W-1:0]    cam_wr_idx,
  input  logic [VID_W-1:0]        cam_wr_vid,
  input  logic [ADDR_W-1:0]       cam_wr_addr,
  output logic                    fm_rd_en,
  output logic [ADDR_W-1:0]       fm_rd_addr,
  input  logic [LANES*FEAT_W-1:0] fm_rd_data,
  input  logic                    drain_req,
  output logic                    out_valid,
  output logic [DST_W-1:0]        out_idx,
  output logic [LANES*ACC_W-1:0]  out_data,
  output logic                    busy,
  output logic                    miss_err
);
  import gagg_pkg::*;

  localparam int EDGE_W = VID_W + DST_W + WGT_W;
  localparam logic [VID_W-1:0] LIM_V = VID_W'(LOCAL_LIMIT);
  localparam logic [DST_W-1:0] LAST_DST = DST_W'(NUM_DST - 1);

  ctl_state_t state_q;
  logic [DST_W-1:0] drn_idx_q;
  logic [LANES*ACC_W-1:0] vbuf [NUM_DST];

  // Named internal events, also observed by the bound checker.
  logic             push, pop, fifo_full, fifo_empty;
  logic [EDGE_W-1:0] head;
  logic [VID_W-1:0] head_src;
  logic [DST_W-1:0] head_dst;
  logic [WGT_W-1:0] head_wgt;
  logic             src_local, cam_hit, resolve_ok;
  logic [ADDR_W-1:0] cam_addr;
  logic             take_edge, start_drain, miss_evt, acc_fire;
  logic [LANES*ACC_W-1:0] mac_out;

  assign push = edge_valid && edge_ready;
  assign edge_ready = !fifo_full;

  gagg_edge_fifo #(.W(EDGE_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push_i(push), .din_i({edge_src, edge_dst, edge_wgt}),
    .pop_i(pop), .dout_o(head),
    .full_o(fifo_full), .empty_o(fifo_empty)
  );

  assign {head_src, head_dst, head_wgt} = head;

  gagg_cam #(.ENTRIES(CAM_ENTRIES), .KEY_W(VID_W), .VAL_W(ADDR_W)) cam_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(cam_wr_en), .wr_idx_i(cam_wr_idx),
    .wr_key_i(cam_wr_vid), .wr_val_i(cam_wr_addr),
    .key_i(head_src), .hit_o(cam_hit), .val_o(cam_addr)
  );

  assign src_local  = (head_src < LIM_V);
  assign resolve_ok = src_local || cam_hit;

  assign start_drain = (state_q == ST_IDLE) && drain_req;
  assign take_edge   = (state_q == ST_IDLE) && !drain_req && !fifo_empty;
  assign fm_rd_en    = take_edge && resolve_ok;
  assign fm_rd_addr  = src_local ? head_src[ADDR_W-1:0] : cam_addr;
  assign miss_evt    = take_edge && !resolve_ok;
  assign acc_fire    = (state_q == ST_ACC);
  assign pop         = miss_evt || acc_fire;

  gagg_mac #(.LANES(LANES), .FEAT_W(FEAT_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) mac_i (
    .acc_i(vbuf[head_dst]), .feat_i(fm_rd_data), .wgt_i(head_wgt), .acc_o(mac_out)
  );

  assign out_valid = (state_q == ST_DRAIN);
  assign out_idx   = drn_idx_q;
  assign out_data  = vbuf[drn_idx_q];
  assign busy      = (state_q != ST_IDLE) || !fifo_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      drn_idx_q <= '0;
      miss_err  <= 1'b0;
    end else begin
      if (miss_evt) miss_err <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (start_drain) begin
            state_q   <= ST_DRAIN;
            drn_idx_q <= '0;
          end else if (fm_rd_en) begin
            state_q <= ST_ACC;
          end
        end
        ST_ACC: state_q <= ST_IDLE;
        ST_DRAIN: begin
          if (drn_idx_q == LAST_DST) state_q <= ST_IDLE;
          drn_idx_q <= drn_idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DST; i++) vbuf[i] <= '0;
    end else if (acc_fire) begin
      vbuf[head_dst] <= mac_out;
    end else if (out_valid) begin
      vbuf[drn_idx_q] <= '0;
    end
  end
endmodule

// File: rtl/gagg_chk.sv
module gagg_chk #(
  parameter int DST_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_err,
  input logic             miss_evt,
  input logic             fm_rd_en,
  input logic             acc_fire,
  input logic             out_valid,
  input logic [DST_W-1:0] out_idx,
  input logic             edge_ready,
  input logic             busy
);
  localparam logic [DST_W-1:0] LAST = '1;

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_err |=> miss_err);

  p_miss_sets_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> miss_err);

  p_read_then_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fm_rd_en |=> acc_fire);

  p_drain_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx != LAST) |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

  p_drain_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_idx == '0));

  p_quiet_in_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!fm_rd_en && !acc_fire));

  p_full_is_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_ready |-> busy);
endmodule

bind gagg_top gagg_chk #(.DST_W(DST_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .miss_err(miss_err), .miss_evt(miss_evt),
  .fm_rd_en(fm_rd_en), .acc_fire(acc_fire),
  .out_valid(out_valid), .out_idx(out_idx),
  .edge_ready(edge_ready), .busy(busy)
);

// File: tb/gagg_top_tb_top.sv
module gagg_top_tb_top;
  localparam int NDST = 8, NL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic edge_valid = 0; logic edge_ready;
  logic [7:0] edge_src = 0; logic [2:0] edge_dst = 0; logic [7:0] edge_wgt = 0;
  logic cam_wr_en = 0; logic [1:0] cam_wr_idx = 0;
  logic [7:0] cam_wr_vid = 0; logic [3:0] cam_wr_addr = 0;
  logic fm_rd_en; logic [3:0] fm_rd_addr; logic [31:0] fm_rd_data = 0;
  logic drain_req = 0, out_valid, busy, miss_err;
  logic [2:0] out_idx; logic [95:0] out_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [23:0] exp_acc [NDST][NL];
  bit   mv [4]; logic [7:0] mk [4]; logic [3:0] ma [4];

  always #5 clk = ~clk;

  gagg_top dut_i (.*);

  function automatic logic [7:0] feat(input int a, input int l);
    return 8'((a * 37 + l * 11 + 5) & 255);
  endfunction

  always_ff @(posedge clk)
    if (fm_rd_en)
      for (int l = 0; l < NL; l++) fm_rd_data[l*8 +: 8] <= feat(int'(fm_rd_addr), l);

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Bench-side address resolution: -1 means miss.
  function automatic int resolve(input int src);
    if (src < 8) return src;
    for (int i = 0; i < 4; i++) if (mv[i] && mk[i] == 8'(src)) return int'(ma[i]);
    return -1;
  endfunction

  task automatic push(input int src, input int dst, input int wgt);
    int a;
    while (!edge_ready) @(negedge clk);
    edge_valid = 1; edge_src = 8'(src); edge_dst = 3'(dst); edge_wgt = 8'(wgt);
    @(negedge clk);
    edge_valid = 0;
    a = resolve(src);
    if (a >= 0)
      for (int l = 0; l < NL; l++)
        exp_acc[dst][l] = exp_acc[dst][l] + 24'(feat(a, l) * wgt);
  endtask

  task automatic cam_write(input int idx, input int vid, input int addr);
    cam_wr_en = 1; cam_wr_idx = 2'(idx); cam_wr_vid = 8'(vid); cam_wr_addr = 4'(addr);
    @(negedge clk);
    cam_wr_en = 0;
    mv[idx] = 1; mk[idx] = 8'(vid); ma[idx] = 4'(addr);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic drain_check(input string tag);
    logic [95:0] e;
    wait_idle();
    drain_req = 1; @(negedge clk); drain_req = 0;
    for (int k = 0; k < NDST; k++) begin
      for (int l = 0; l < NL; l++) e[l*24 +: 24] = exp_acc[k][l];
      chk({tag, " R7 valid"}, 96'(out_valid), 96'(1));
      chk({tag, " R7 idx"}, 96'(out_idx), 96'(k));
      chk({tag, " R5 data"}, out_data, e);
      @(negedge clk);
    end
    chk({tag, " R7 end"}, 96'(out_valid), 96'(0));
    for (int k = 0; k < NDST; k++) for (int l = 0; l < NL; l++) exp_acc[k][l] = '0;
  endtask

  initial begin
    for (int k = 0; k < NDST; k++) for (int l = 0; l < NL; l++) exp_acc[k][l] = '0;
    for (int i = 0; i < 4; i++) begin mv[i] = 0; mk[i] = 0; ma[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9: reset state
    chk("R9 ready", 96'(edge_ready), 96'(1));
    chk("R9 out_valid", 96'(out_valid), 96'(0));
    chk("R9 busy", 96'(busy), 96'(0));
    chk("R9 miss_err", 96'(miss_err), 96'(0));
    drain_check("R9 zero buffer");

    // R2/R5/R6: every local source into every destination
    for (int s = 0; s < 8; s++)
      for (int d = 0; d < NDST; d++) push(s, d, (s * 5 + d * 3 + 1) & 255);
    drain_check("R2 local sweep");
    drain_check("R7 cleared");

    // R3: CAM resolution, ID 8 is first remote ID, duplicate key 100
    cam_write(0, 100, 9);
    cam_write(1, 200, 12);
    cam_write(2, 8, 15);
    cam_write(3, 100, 10);
    push(100, 1, 3);
    push(200, 2, 250);
    push(8, 5, 17);
    push(7, 5, 2);
    wait_idle();
    chk("R4 no miss yet", 96'(miss_err), 96'(0));
    // R4: miss on ID 50, dropped
    push(50, 0, 99);
    wait_idle();
    chk("R4 miss flag", 96'(miss_err), 96'(1));
    cam_write(0, 201, 11);   // now ID 100 resolves via entry 3
    push(100, 3, 4);
    push(201, 4, 6);
    wait_idle();
    chk("R4 sticky", 96'(miss_err), 96'(1));
    drain_check("R3 cam");

    // R5: accumulator wrap
    for (int i = 0; i < 700; i++) push(3, 7, 255);
    drain_check("R5 wrap");

    // R1/R8: fill the queue while draining
    wait_idle();
    drain_req = 1; @(negedge clk); drain_req = 0;
    for (int i = 0; i < 4; i++) push(i + 1, 6, 10 + i);
    chk("R1 full", 96'(edge_ready), 96'(0));
    chk("R8 draining", 96'(out_valid), 96'(1));
    drain_check("R8 queued applied");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule